// File: doc/BRIEF.md
# Evaluation Board Control Register File

This block is the small register file that a board-level CPU uses to drive the front-panel indicators and a few board pins. A plain read/write bus with address, write data, write strobe, read strobe and read data reaches an 8-bit LED bar, an eight-character ASCII display buffer, a software reset trigger, an 8-bit general-purpose output, and the pins used to bit-bang a serial EEPROM over I2C. The LED and display contents leave the block as parallel outputs, so a separate renderer can show them.

A single 32-bit write to the word register turns the value into eight uppercase hexadecimal characters. Individual characters can then be changed through per-character byte registers. Read data is registered and appears in the cycle after the read strobe. Any access to an offset that is not mapped returns zero, changes nothing and raises a one-cycle error pulse. The sub-window reserved for a neighbouring UART stays silent.

Top module: `bcr_top`

## Requirements
- R1: Only the low 20 address bits are decoded, so any upper address bits are ignored.
- R2: An access in the offset window 0x900 to 0x9FF reads zero, raises no error pulse and changes no state.
- R3: A write to offset 0x010 stores the low 8 data bits in the LED bar, where bit i drives LED position i. A read of that offset returns the stored value zero-extended.
- R4: A write to offset 0x410 sets display character i (output bits 8i+7 to 8i) to the uppercase ASCII hex digit of data nibble 7-i, so character 0 shows the most significant nibble. A read of offset 0x410 returns zero.
- R5: A write to offset 0x418 + 8k, for k from 0 to 7, stores the low data byte in character k. A read of that offset returns character k. Offsets inside this range that are not a multiple of 8 from 0x418 are unmapped.
- R6: After reset the display holds eight spaces (0x20), the LED bar and the general-purpose output are zero, SCL and SDA are driven high, the output-enable field is 0 and the select bit is 0.
- R7: A write to offset 0x500 makes the reset request high for exactly the one cycle after the write. A read of offset 0x500 returns zero.
- R8: A write to offset 0xB10 drives SCL from data bit 1 and SDA from data bit 0. Offset 0xB08 keeps 2 output-enable bits and offset 0xB18 keeps 1 select bit. All three offsets read back what they store.
- R9: A read of offset 0xB00 returns the current SCL output in bit 1 and the EEPROM data line in bit 0, with all other bits zero.
- R10: Offset 0x000 reads zero. A write to offset 0x040 keeps the low 8 data bits on the general-purpose output, and a read of 0x040 returns them.
- R11: A read or write of any other offset returns zero, changes no state, and raises the error pulse for exactly the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address; only the low 20 bits are decoded |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |
| led_bar | output | 8 | LED bar state |
| disp_chars | output | 64 | Display buffer; character i in bits 8i+7 to 8i |
| gpo | output | 8 | General-purpose output |
| sys_rst_req | output | 1 | One-cycle system reset request |
| i2c_scl | output | 1 | Bit-banged I2C clock |
| i2c_sda | output | 1 | Bit-banged I2C data |
| i2c_oe | output | 2 | Stored output-enable field |
| i2c_sel | output | 1 | Stored select bit |
| eeprom_sda_in | input | 1 | Data line returned by the EEPROM |

## Verification
The hardest cases are the edges of the character window. A misaligned offset such as 0x41C lies between two valid character slots but must count as unmapped, and the last slot at 0x450 must still decode. The stimulus reaches these edges directly from the vector table and then checks the whole display output, so a stray write would show up. A second hard case is the I2C input read, because it mixes a stored output bit with a live input pin. The bench changes SCL and the EEPROM line independently between reads so that each source is seen on its own.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   localparam int OFF_SWITCH  = 'h000;
   localparam int OFF_LED     = 'h010;
   localparam int OFF_GPO     = 'h040;
   localparam int OFF_WORD    = 'h410;
   localparam int OFF_CHAR0   = 'h418;
   localparam int OFF_SRST    = 'h500;
   localparam int OFF_I2C_IN  = 'hB00;
   localparam int OFF_I2C_OE  = 'hB08;
   localparam int OFF_I2C_OUT = 'hB10;
   localparam int OFF_I2C_SEL = 'hB18;
   localparam int HOLE_PAGE   = 'h9;

   typedef struct packed {
      logic sw;
      logic led;
      logic gpo;
      logic word;
      logic chr;
      logic srst;
      logic i2c_in;
      logic i2c_oe;
      logic i2c_out;
      logic i2c_sel;
      logic hole;
      logic bad;
   } bcr_hit_t;

   function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
   endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
   import bcr_pkg::*;
#(
   parameter int OFF_W       = 20,
   parameter int N_CHARS     = 8,
   parameter int CHAR_STRIDE = 8,
   localparam int IDX_W      = (N_CHARS > 1) ? $clog2(N_CHARS) : 1,
   localparam int SH         = $clog2(CHAR_STRIDE)
) (
   input  logic [OFF_W-1:0] off,
   output bcr_hit_t         hit,
   output logic [IDX_W-1:0] chr_idx
);

   logic [OFF_W-1:0] diff;
   logic             in_chars;

   if ((1 << SH) != CHAR_STRIDE) begin : g_stride_bad
      $error("CHAR_STRIDE must be a power of two");
   end

   always_comb begin
      diff     = off - OFF_W'(OFF_CHAR0);
      in_chars = (off >= OFF_W'(OFF_CHAR0)) &&
                 (diff < OFF_W'(N_CHARS * CHAR_STRIDE)) &&
                 (diff[SH-1:0] == '0);
      chr_idx  = diff[SH +: IDX_W];
   end

   always_comb begin
      hit = '0;
      if (off[OFF_W-1:8] == (OFF_W-8)'(HOLE_PAGE)) begin
         hit.hole = 1'b1;
      end else if (in_chars) begin
         hit.chr = 1'b1;
      end else begin
         case (off)
            OFF_W'(OFF_SWITCH):  hit.sw      = 1'b1;
            OFF_W'(OFF_LED):     hit.led     = 1'b1;
            OFF_W'(OFF_GPO):     hit.gpo     = 1'b1;
            OFF_W'(OFF_WORD):    hit.word    = 1'b1;
            OFF_W'(OFF_SRST):    hit.srst    = 1'b1;
            OFF_W'(OFF_I2C_IN):  hit.i2c_in  = 1'b1;
            OFF_W'(OFF_I2C_OE):  hit.i2c_oe  = 1'b1;
            OFF_W'(OFF_I2C_OUT): hit.i2c_out = 1'b1;
            OFF_W'(OFF_I2C_SEL): hit.i2c_sel = 1'b1;
            default:             hit.bad     = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/bcr_display.sv
module bcr_display
   import bcr_pkg::*;
#(
   parameter int N_CHARS  = 8,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 word_we,
   input  logic                 chr_we,
   input  logic [IDX_W-1:0]     chr_idx,
   input  logic [DATA_W-1:0]    wdata,
   output logic [8*N_CHARS-1:0] chars
);

   for (genvar i = 0; i < N_CHARS; i++) begin : g_char
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chars[8*i +: 8] <= 8'h20;
         end else if (word_we) begin
            chars[8*i +: 8] <= nib_to_ascii(wdata[4*(N_CHARS-1-i) +: 4]);
         end else if (chr_we && (chr_idx == IDX_W'(i))) begin
            chars[8*i +: 8] <= wdata[7:0];
         end
      end
   end

endmodule

// File: rtl/bcr_i2c.sv
module bcr_i2c #(
   parameter int OE_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            out_we,
   input  logic            oe_we,
   input  logic            sel_we,
   input  logic [OE_W-1:0] wbits,
   output logic            scl,
   output logic            sda,
   output logic [OE_W-1:0] oe,
   output logic            sel
);

   if (OE_W < 2) begin : g_oe_bad
      $error("OE_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl <= 1'b1;
         sda <= 1'b1;
         oe  <= '0;
         sel <= 1'b0;
      end else begin
         if (out_we) begin
            scl <= wbits[1];
            sda <= wbits[0];
         end
         if (oe_we)  oe  <= wbits;
         if (sel_we) sel <= wbits[0];
      end
   end

endmodule

// File: rtl/bcr_top.sv
module bcr_top
   import bcr_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int DEC_W       = 20,
   parameter int N_CHARS     = 8,
   parameter int CHAR_STRIDE = 8,
   parameter int LED_W       = 8,
   parameter int GPO_W       = 8,
   parameter int OE_W        = 2,
   localparam int IDX_W      = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_we,
   input  logic                 bus_re,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bad_access,
   output logic [LED_W-1:0]     led_bar,
   output logic [8*N_CHARS-1:0] disp_chars,
   output logic [GPO_W-1:0]     gpo,
   output logic                 sys_rst_req,
   output logic                 i2c_scl,
   output logic                 i2c_sda,
   output logic [OE_W-1:0]      i2c_oe,
   output logic                 i2c_sel,
   input  logic                 eeprom_sda_in
);

   if (DATA_W != 4 * N_CHARS) begin : g_w_bad
      $error("DATA_W must hold one nibble per display character");
   end
   if (DEC_W < 12 || DEC_W > ADDR_W) begin : g_dec_bad
      $error("DEC_W must cover the register map and fit the address");
   end
   if (LED_W > DATA_W || GPO_W > DATA_W || LED_W < 8 || GPO_W < 8) begin : g_reg_bad
      $error("LED_W and GPO_W must lie between 8 and DATA_W");
   end

   bcr_hit_t          hit;
   logic [IDX_W-1:0]  chr_idx;
   logic [DATA_W-1:0] rd_mux;

   bcr_decode #(
      .OFF_W(DEC_W), .N_CHARS(N_CHARS), .CHAR_STRIDE(CHAR_STRIDE)
   ) u_dec (
      .off(bus_addr[DEC_W-1:0]), .hit(hit), .chr_idx(chr_idx)
   );

   bcr_display #(
      .N_CHARS(N_CHARS), .DATA_W(DATA_W)
   ) u_disp (
      .clk(clk), .rst_n(rst_n),
      .word_we(bus_we && hit.word),
      .chr_we(bus_we && hit.chr),
      .chr_idx(chr_idx), .wdata(bus_wdata), .chars(disp_chars)
   );

   bcr_i2c #(
      .OE_W(OE_W)
   ) u_i2c (
      .clk(clk), .rst_n(rst_n),
      .out_we(bus_we && hit.i2c_out),
      .oe_we(bus_we && hit.i2c_oe),
      .sel_we(bus_we && hit.i2c_sel),
      .wbits(bus_wdata[OE_W-1:0]),
      .scl(i2c_scl), .sda(i2c_sda), .oe(i2c_oe), .sel(i2c_sel)
   );

   always_comb begin
      rd_mux = '0;
      if (hit.led)     rd_mux = DATA_W'(led_bar);
      if (hit.gpo)     rd_mux = DATA_W'(gpo);
      if (hit.chr)     rd_mux = DATA_W'(disp_chars[8*chr_idx +: 8]);
      if (hit.i2c_in)  rd_mux = DATA_W'({i2c_scl, eeprom_sda_in});
      if (hit.i2c_oe)  rd_mux = DATA_W'(i2c_oe);
      if (hit.i2c_out) rd_mux = DATA_W'({i2c_scl, i2c_sda});
      if (hit.i2c_sel) rd_mux = DATA_W'(i2c_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_bar     <= '0;
         gpo         <= '0;
         sys_rst_req <= 1'b0;
         bus_rdata   <= '0;
         bad_access  <= 1'b0;
      end else begin
         if (bus_we && hit.led) led_bar <= bus_wdata[LED_W-1:0];
         if (bus_we && hit.gpo) gpo     <= bus_wdata[GPO_W-1:0];
         sys_rst_req <= bus_we && hit.srst;
         bad_access  <= (bus_we || bus_re) && hit.bad;
         if (bus_re) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/bcr_chk.sv
module bcr_chk
   import bcr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEC_W  = 20,
   parameter int LED_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bad_access,
   input logic              sys_rst_req,
   input logic [LED_W-1:0]  led_bar
);

   logic [DEC_W-1:0] off;
   logic             in_hole;
   assign off     = bus_addr[DEC_W-1:0];
   assign in_hole = (off[DEC_W-1:8] == (DEC_W-8)'(HOLE_PAGE));

   // R7
   srst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && off == DEC_W'(OFF_SRST)) |=> sys_rst_req);

   // R7
   srst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(bus_we && off == DEC_W'(OFF_SRST)));

   // R2
   hole_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_we || bus_re) && in_hole) |=> !bad_access);

   // R2
   hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && in_hole) |=> (bus_rdata == '0));

   // R11
   bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_access && $past(bus_re)) |-> (bus_rdata == '0));

   // R11
   bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(bus_we || bus_re));

   // R3
   led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && off == DEC_W'(OFF_LED)) |=> $stable(led_bar));

endmodule

bind bcr_top bcr_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_W(DEC_W), .LED_W(LED_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_re(bus_re), .bus_rdata(bus_rdata), .bad_access(bad_access),
   .sys_rst_req(sys_rst_req), .led_bar(led_bar)
);

// File: tb/sim_bcr_top.sv
module sim_bcr_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic        eeprom_sda_in = 1'b0;
   logic [31:0] bus_rdata;
   logic        bad_access;
   logic [7:0]  led_bar;
   logic [63:0] disp_chars;
   logic [7:0]  gpo;
   logic        sys_rst_req;
   logic        i2c_scl, i2c_sda, i2c_sel;
   logic [1:0]  i2c_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bcr_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .bad_access(bad_access), .led_bar(led_bar), .disp_chars(disp_chars),
      .gpo(gpo), .sys_rst_req(sys_rst_req), .i2c_scl(i2c_scl),
      .i2c_sda(i2c_sda), .i2c_oe(i2c_oe), .i2c_sel(i2c_sel),
      .eeprom_sda_in(eeprom_sda_in)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [19:0] addr;
      logic [31:0] data;
      logic        bad;
   } vec_t;

   localparam logic [1:0] OP_W = 2'd1;
   localparam logic [1:0] OP_R = 2'd2;
   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{OP_W, 20'h00010, 32'h1234_56A5, 1'b0},  // R3
      '{OP_R, 20'h00010, 32'h0000_00A5, 1'b0},  // R3
      '{OP_W, 20'h00040, 32'hFFFF_FF3C, 1'b0},  // R10
      '{OP_R, 20'h00040, 32'h0000_003C, 1'b0},  // R10
      '{OP_R, 20'h00000, 32'h0000_0000, 1'b0},  // R10
      '{OP_W, 20'h00410, 32'hDEAD_BEEF, 1'b0},  // R4
      '{OP_R, 20'h00418, 32'h0000_0044, 1'b0},  // R5
      '{OP_R, 20'h00450, 32'h0000_0046, 1'b0},  // R5
      '{OP_W, 20'h00428, 32'h0000_017A, 1'b0},  // R5
      '{OP_R, 20'h00428, 32'h0000_007A, 1'b0},  // R5
      '{OP_R, 20'h00420, 32'h0000_0045, 1'b0},  // R5
      '{OP_W, 20'h00B08, 32'h0000_00FF, 1'b0},  // R8
      '{OP_R, 20'h00B08, 32'h0000_0003, 1'b0},  // R8
      '{OP_W, 20'h00B18, 32'h0000_0003, 1'b0},  // R8
      '{OP_R, 20'h00B18, 32'h0000_0001, 1'b0},  // R8
      '{OP_R, 20'h00904, 32'h0000_0000, 1'b0},  // R2
      '{OP_W, 20'h009F0, 32'h0000_00FF, 1'b0},  // R2
      '{OP_R, 20'h00123, 32'h0000_0000, 1'b1},  // R11
      '{OP_W, 20'h0041C, 32'h0000_0055, 1'b1},  // R11
      '{OP_R, 20'h0041C, 32'h0000_0000, 1'b1},  // R11
      '{OP_R, 20'h00410, 32'h0000_0000, 1'b0}   // R4
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d, output logic bad);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bad = bad_access;
      bus_we = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic bad);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      d = bus_rdata; bad = bad_access;
      bus_re = 1'b0;
   endtask

   function automatic logic [7:0] hexc(input logic [3:0] n);
      return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
   endfunction

   function automatic logic [63:0] word_disp(input logic [31:0] w);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = hexc(w[28-4*i +: 4]);
      return r;
   endfunction

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic        b;
      logic [31:0] d;
      logic [63:0] snap;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 reset state
      check("R6 display", disp_chars, {8{8'h20}});
      check("R6 led", 64'(led_bar), 64'h0);
      check("R6 gpo", 64'(gpo), 64'h0);
      check("R6 scl/sda", 64'({i2c_scl, i2c_sda}), 64'h3);
      check("R6 oe/sel", 64'({i2c_oe, i2c_sel}), 64'h0);
      check("R7 idle", 64'(sys_rst_req), 64'h0);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k].op == OP_W) begin
            do_write({12'h000, VEC[k].addr}, VEC[k].data, b);
            check($sformatf("vec%0d bad flag", k), 64'(b), 64'(VEC[k].bad));
         end else begin
            do_read({12'h000, VEC[k].addr}, d, b);
            check($sformatf("vec%0d rdata", k), 64'(d), 64'(VEC[k].data));
            check($sformatf("vec%0d bad flag", k), 64'(b), 64'(VEC[k].bad));
         end
      end
      check("R3 led port", 64'(led_bar), 64'hA5);
      check("R10 gpo port", 64'(gpo), 64'h3C);
      check("R8 oe/sel ports", 64'({i2c_oe, i2c_sel}), 64'h7);

      // R1 upper address bits ignored
      do_write(32'hFFF0_0010, 32'h0000_000F, b);
      check("R1 led via aliased address", 64'(led_bar), 64'h0F);
      do_read(32'h5A50_0040, d, b);
      check("R1 gpo read via aliased address", 64'(d), 64'h3C);

      // R4 word conversion, full buffer
      do_write(32'h0000_0410, 32'h0123_89AB, b);
      check("R4 word to hex", disp_chars, word_disp(32'h0123_89AB));

      // R5 each character slot
      for (int k = 0; k < 8; k++) begin
         do_write(32'h418 + 32'(8 * k), 32'h100 + 32'h61 + 32'(k), b);
      end
      check("R5 per-char writes", disp_chars, 64'h6867_6665_6463_6261);

      // R2 / R11 no state change
      snap = disp_chars;
      do_write(32'h0000_0910, 32'h0000_0000, b);
      do_write(32'h0000_0600, 32'h0000_0000, b);
      check("R11 unmapped write bad", 64'(b), 64'h1);
      do_write(32'h0000_041C, 32'h0000_0000, b);
      check("R2 R11 display untouched", disp_chars, snap);
      check("R2 R11 led untouched", 64'(led_bar), 64'h0F);
      @(negedge clk);
      check("R11 pulse one cycle", 64'(bad_access), 64'h0);

      // R7 soft reset pulse
      do_write(32'h0000_0500, 32'h0000_0001, b);
      check("R7 request high", 64'(sys_rst_req), 64'h1);
      @(negedge clk);
      check("R7 request drops", 64'(sys_rst_req), 64'h0);
      do_read(32'h0000_0500, d, b);
      check("R7 reads zero", 64'(d), 64'h0);

      // R8 pin mapping
      do_write(32'h0000_0B10, 32'h0000_0002, b);
      check("R8 scl=1 sda=0", 64'({i2c_scl, i2c_sda}), 64'h2);
      do_write(32'h0000_0B10, 32'h0000_0001, b);
      check("R8 scl=0 sda=1", 64'({i2c_scl, i2c_sda}), 64'h1);
      do_read(32'h0000_0B10, d, b);
      check("R8 out readback", 64'(d), 64'h1);

      // R9 input register mixes SCL and EEPROM line
      eeprom_sda_in = 1'b1;
      do_read(32'h0000_0B00, d, b);
      check("R9 scl0 eeprom1", 64'(d), 64'h1);
      eeprom_sda_in = 1'b0;
      do_write(32'h0000_0B10, 32'h0000_0003, b);
      do_read(32'h0000_0B00, d, b);
      check("R9 scl1 eeprom0", 64'(d), 64'h2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule